// File: doc/BRIEF.md
# LIN Node Sleep and Wake Controller

This block keeps track of whether a bus node is in its low-power state. It watches the decoded frames handed up by the frame transceiver. It also watches the raw bus line, a bit-time tick and a local wake request. From these it raises a sleep indication for the power logic. The node goes to sleep when it sees the go-to-sleep command frame, or when the bus has stayed recessive for a set number of bit times. Any dominant bit restarts that count.

While asleep, a falling edge to the dominant level on the bus only arms the wake-up. The node leaves sleep only if a frame whose first data byte is the wake value 0x80 arrives within a window of bit times. If the window runs out, the node returns to sleep and pulses a bad-wake flag, so a glitch or noise on the line cannot keep the node awake. A local event instead asks the transceiver to send a wake frame. After that request the node waits, within the same window, for any valid frame that shows traffic has resumed.

Top module: `lin_sleep_wake_ctrl`

## Requirements
- R1: During and right after reset, `asleep`, `wake_tx_req`, `wake_ok` and `bad_wake` are all 0, so the node starts awake.
- R2: While awake, a cycle with `frm_valid`=1, `frm_id`=0x3C and `frm_data0`=0x00 makes `asleep` 1 one cycle later. A frame with a different identifier or data byte, or one without `frm_valid`, has no effect. Repeating the command while asleep changes nothing.
- R3: While awake, once `IDLE_BITS` cycles with `bit_tick`=1 have passed with the bus recessive (`bus_rx`=1), `asleep` goes to 1 one cycle after the last tick is counted. A dominant level (`bus_rx`=0) seen on the bus restarts the count.
- R4: While asleep, a valid frame that is not preceded by a dominant edge does not wake the node. A dominant edge (after `SYNC_STAGES` synchronizer flops) arms a wake check, and `asleep` stays 1 during that check.
- R5: During an armed wake check, a valid frame with `frm_data0`=0x80 drops `asleep` to 0 and pulses `wake_ok` for exactly one cycle.
- R6: If `WAKE_WIN_BITS` bit ticks pass during an armed check without a wake frame, `bad_wake` pulses for one cycle and `asleep` stays 1. A later wake frame is then ignored until a new dominant edge arrives.
- R7: If the wake frame arrives in the same cycle as the window expiry, the frame wins: `wake_ok` pulses and `bad_wake` stays 0.
- R8: `local_wake` while asleep pulses `wake_tx_req` for one cycle. After that, any valid frame within `WAKE_WIN_BITS` ticks wakes the node with a `wake_ok` pulse. If no frame arrives in that window, `bad_wake` pulses and the node stays asleep.
- R9: `local_wake` while awake is ignored: `wake_tx_req` stays 0 and `asleep` stays 0.
- R10: During an armed wake check, valid frames whose first data byte is not 0x80 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| bus_rx | input | 1 | Raw bus level, 1 recessive, 0 dominant |
| frm_valid | input | 1 | Decoded frame received correctly (one-cycle pulse) |
| frm_id | input | 8 | Identifier of the decoded frame |
| frm_data0 | input | 8 | First data byte of the decoded frame |
| local_wake | input | 1 | Local wake event request |
| asleep | output | 1 | Node is in (or confirming exit from) sleep |
| wake_tx_req | output | 1 | One-cycle request to transmit a wake frame |
| wake_ok | output | 1 | One-cycle pulse: wake-up confirmed |
| bad_wake | output | 1 | One-cycle pulse: wake-up not confirmed in time |

## Verification
Two things can fall in the same cycle: the arrival of the confirming wake frame and the expiry of the wake window. The bench provokes this by arming a check with a dominant edge and then feeding exactly `WAKE_WIN_BITS` consecutive ticks. In the very next cycle it presents the 0x80 frame, so the frame lands on the same edge at which the window counter reports expiry. The bench judges the result as correct only if `wake_ok` rises, `asleep` falls and `bad_wake` stays low on that edge. It runs a second case with no frame in that cycle, which must give the opposite result.

// File: rtl/lsw_pkg.sv
package lsw_pkg;
  typedef enum logic [1:0] {
    ST_AWAKE      = 2'd0,
    ST_ASLEEP     = 2'd1,
    ST_WAKE_PEND  = 2'd2,
    ST_LOCAL_WAIT = 2'd3
  } lsw_state_e;

  localparam logic [7:0] SLEEP_CMD_ID   = 8'h3C;
  localparam logic [7:0] SLEEP_CMD_DATA = 8'h00;
  localparam logic [7:0] WAKE_DATA      = 8'h80;
endpackage

// File: rtl/lsw_bus_sync.sv
module lsw_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bus_rx,
  output logic bus_lvl,
  output logic dom_edge
);
  localparam int MSB = STAGES - 1;

  logic [STAGES-1:0] sh;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '1;
      prev <= 1'b1;
    end else begin
      sh   <= {sh[STAGES-2:0], bus_rx};
      prev <= sh[MSB];
    end
  end

  assign bus_lvl  = sh[MSB];
  assign dom_edge = prev & ~sh[MSB];
endmodule

// File: rtl/lsw_tick_counter.sv
module lsw_tick_counter #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic tick,
  output logic done
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (tick && cnt != LIM) cnt <= cnt + 1'b1;
  end

  assign done = (cnt == LIM);
endmodule

// File: rtl/lin_sleep_wake_ctrl.sv
module lin_sleep_wake_ctrl
  import lsw_pkg::*;
#(
  parameter int IDLE_BITS     = 25000,
  parameter int WAKE_WIN_BITS = 200,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_tick,
  input  logic       bus_rx,
  input  logic       frm_valid,
  input  logic [7:0] frm_id,
  input  logic [7:0] frm_data0,
  input  logic       local_wake,
  output logic       asleep,
  output logic       wake_tx_req,
  output logic       wake_ok,
  output logic       bad_wake
);
  lsw_state_e state, nxt;
  logic bus_lvl, dom_edge, idle_done, win_done;
  logic sleep_cmd, wake_frm, tx_n, ok_n, bad_n;

  lsw_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .bus_rx(bus_rx),
    .bus_lvl(bus_lvl), .dom_edge(dom_edge)
  );

  lsw_tick_counter #(.LIMIT(IDLE_BITS)) u_idle (
    .clk(clk), .rst(rst),
    .clear((state != ST_AWAKE) || !bus_lvl),
    .tick(bit_tick), .done(idle_done)
  );

  lsw_tick_counter #(.LIMIT(WAKE_WIN_BITS)) u_win (
    .clk(clk), .rst(rst),
    .clear((state != ST_WAKE_PEND) && (state != ST_LOCAL_WAIT)),
    .tick(bit_tick), .done(win_done)
  );

  assign sleep_cmd = frm_valid && (frm_id == SLEEP_CMD_ID) && (frm_data0 == SLEEP_CMD_DATA);
  assign wake_frm  = frm_valid && (frm_data0 == WAKE_DATA);

  always_comb begin
    nxt   = state;
    tx_n  = 1'b0;
    ok_n  = 1'b0;
    bad_n = 1'b0;
    unique case (state)
      ST_AWAKE:
        if (sleep_cmd || idle_done) nxt = ST_ASLEEP;
      ST_ASLEEP:
        if (local_wake) begin
          nxt  = ST_LOCAL_WAIT;
          tx_n = 1'b1;
        end else if (dom_edge) begin
          nxt = ST_WAKE_PEND;
        end
      ST_WAKE_PEND:
        if (wake_frm) begin
          nxt  = ST_AWAKE;
          ok_n = 1'b1;
        end else if (win_done) begin
          nxt   = ST_ASLEEP;
          bad_n = 1'b1;
        end
      ST_LOCAL_WAIT:
        if (frm_valid) begin
          nxt  = ST_AWAKE;
          ok_n = 1'b1;
        end else if (win_done) begin
          nxt   = ST_ASLEEP;
          bad_n = 1'b1;
        end
      default: nxt = ST_AWAKE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_AWAKE;
      asleep      <= 1'b0;
      wake_tx_req <= 1'b0;
      wake_ok     <= 1'b0;
      bad_wake    <= 1'b0;
    end else begin
      state       <= nxt;
      asleep      <= (nxt != ST_AWAKE);
      wake_tx_req <= tx_n;
      wake_ok     <= ok_n;
      bad_wake    <= bad_n;
    end
  end
endmodule

// File: rtl/lsw_checker.sv
module lsw_checker (
  input logic       clk,
  input logic       rst,
  input logic       frm_valid,
  input logic [7:0] frm_id,
  input logic [7:0] frm_data0,
  input logic       local_wake,
  input logic       asleep,
  input logic       wake_tx_req,
  input logic       wake_ok,
  input logic       bad_wake
);
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!asleep && !wake_tx_req && !wake_ok && !bad_wake)); // R1

  AST_SLEEP_CMD: assert property (@(posedge clk) disable iff (rst)
    (frm_valid && frm_id == 8'h3C && frm_data0 == 8'h00 && !asleep && !$past(asleep))
      |=> asleep); // R2

  AST_OK_AWAKE: assert property (@(posedge clk) disable iff (rst)
    wake_ok |-> (!asleep && $past(asleep))); // R5

  AST_BAD_ASLEEP: assert property (@(posedge clk) disable iff (rst)
    bad_wake |-> asleep); // R6

  AST_OK_BAD_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(wake_ok && bad_wake)); // R7

  AST_TX_PULSE: assert property (@(posedge clk) disable iff (rst)
    wake_tx_req |=> !wake_tx_req); // R8

  AST_TX_SOURCE: assert property (@(posedge clk) disable iff (rst)
    wake_tx_req |-> (asleep && $past(local_wake) && $past(asleep))); // R9
endmodule

bind lin_sleep_wake_ctrl lsw_checker u_chk (
  .clk(clk), .rst(rst), .frm_valid(frm_valid), .frm_id(frm_id),
  .frm_data0(frm_data0), .local_wake(local_wake), .asleep(asleep),
  .wake_tx_req(wake_tx_req), .wake_ok(wake_ok), .bad_wake(bad_wake)
);

// File: tb/tb_lin_sleep_wake_ctrl.sv
module tb_lin_sleep_wake_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int IDLE_N     = 8;
  localparam int WIN_N      = 5;
  localparam int NVEC       = 14;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_tick = 1'b0, bus_rx = 1'b1, frm_valid = 1'b0, local_wake = 1'b0;
  logic [7:0] frm_id = 8'h00, frm_data0 = 8'h00;
  logic asleep, wake_tx_req, wake_ok, bad_wake;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lin_sleep_wake_ctrl #(.IDLE_BITS(IDLE_N), .WAKE_WIN_BITS(WIN_N), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .bus_rx(bus_rx),
    .frm_valid(frm_valid), .frm_id(frm_id), .frm_data0(frm_data0),
    .local_wake(local_wake), .asleep(asleep), .wake_tx_req(wake_tx_req),
    .wake_ok(wake_ok), .bad_wake(bad_wake)
  );

  // {valid, id, data0, local, exp {asleep, tx_req, ok, bad}}
  localparam logic [21:0] VEC [NVEC] = '{
    {1'b0, 8'h00, 8'h00, 1'b0, 4'b0000},  // R1 idle awake
    {1'b1, 8'h3C, 8'h01, 1'b0, 4'b0000},  // R2 wrong data byte
    {1'b1, 8'h3D, 8'h00, 1'b0, 4'b0000},  // R2 wrong id
    {1'b0, 8'h3C, 8'h00, 1'b0, 4'b0000},  // R2 not valid
    {1'b0, 8'h00, 8'h00, 1'b1, 4'b0000},  // R9 local while awake
    {1'b1, 8'h3C, 8'h00, 1'b0, 4'b1000},  // R2 sleep command
    {1'b1, 8'h3C, 8'h00, 1'b0, 4'b1000},  // R2 repeat while asleep
    {1'b1, 8'h00, 8'h80, 1'b0, 4'b1000},  // R4 frame without edge
    {1'b0, 8'h00, 8'h00, 1'b1, 4'b1100},  // R8 local wake
    {1'b0, 8'h00, 8'h00, 1'b0, 4'b1000},  // R8 tx pulse ends
    {1'b1, 8'h22, 8'h55, 1'b0, 4'b0010},  // R8 any frame confirms
    {1'b0, 8'h00, 8'h00, 1'b0, 4'b0000},  // R8 ok pulse ends
    {1'b1, 8'h3C, 8'h00, 1'b0, 4'b1000},  // R2 sleep again
    {1'b0, 8'h00, 8'h00, 1'b0, 4'b1000}   // R2 stays asleep
  };

  task automatic step(input logic b, input logic t, input logic v,
                      input logic [7:0] id, input logic [7:0] d0, input logic lw);
    @(negedge clk);
    bus_rx = b; bit_tick = t; frm_valid = v; frm_id = id; frm_data0 = d0; local_wake = lw;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    step(1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0);
  endtask

  task automatic chk(input string req, input logic [3:0] exp);
    logic [3:0] act;
    act = {asleep, wake_tx_req, wake_ok, bad_wake};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {asleep,tx,ok,bad} actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic arm_by_edge();
    step(1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0);
    for (int k = 0; k < 4; k++) idle();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1", 4'b0000);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    chk("R1", 4'b0000);

    for (int i = 0; i < NVEC; i++) begin
      step(1'b1, 1'b0, VEC[i][21], VEC[i][20:13], VEC[i][12:5], VEC[i][4]);
      chk($sformatf("table[%0d]", i), VEC[i][3:0]);
    end

    // dominant edge wake with confirmation, non-wake frame ignored
    arm_by_edge();
    chk("R4", 4'b1000);
    step(1'b1, 1'b0, 1'b1, 8'h10, 8'h00, 1'b0);
    chk("R10", 4'b1000);
    step(1'b1, 1'b0, 1'b1, 8'h00, 8'h80, 1'b0);
    chk("R5", 4'b0010);
    idle();
    chk("R5", 4'b0000);

    // idle timeout, with a dominant restart in the middle
    for (int k = 0; k < 6; k++) step(1'b1, 1'b1, 1'b0, 8'h00, 8'h00, 1'b0);
    for (int k = 0; k < 3; k++) step(1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0);
    for (int k = 0; k < 3; k++) idle();
    for (int k = 0; k < IDLE_N - 1; k++) step(1'b1, 1'b1, 1'b0, 8'h00, 8'h00, 1'b0);
    chk("R3", 4'b0000);
    step(1'b1, 1'b1, 1'b0, 8'h00, 8'h00, 1'b0);
    chk("R3", 4'b0000);
    idle();
    chk("R3", 4'b1000);

    // bad wake: window expiry without a wake frame
    arm_by_edge();
    for (int k = 0; k < WIN_N; k++) step(1'b1, 1'b1, 1'b0, 8'h00, 8'h00, 1'b0);
    chk("R6", 4'b1000);
    idle();
    chk("R6", 4'b1001);
    idle();
    chk("R6", 4'b1000);
    step(1'b1, 1'b0, 1'b1, 8'h00, 8'h80, 1'b0);
    chk("R6", 4'b1000);

    // wake frame on the same edge as window expiry
    arm_by_edge();
    for (int k = 0; k < WIN_N; k++) step(1'b1, 1'b1, 1'b0, 8'h00, 8'h00, 1'b0);
    step(1'b1, 1'b0, 1'b1, 8'h00, 8'h80, 1'b0);
    chk("R7", 4'b0010);

    // local wake with no answer in the window
    step(1'b1, 1'b0, 1'b1, 8'h3C, 8'h00, 1'b0);
    chk("R2", 4'b1000);
    step(1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 1'b1);
    chk("R8", 4'b1100);
    for (int k = 0; k < WIN_N; k++) step(1'b1, 1'b1, 1'b0, 8'h00, 8'h00, 1'b0);
    chk("R8", 4'b1000);
    idle();
    chk("R8", 4'b1001);
    idle();
    chk("R8", 4'b1000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule